// File: doc/BRIEF.md
# Low-Speed Preamble Transmit Sequencer

This block takes one low-speed packet from a link-side byte stream and sends it onto a full-speed bus segment, so that a hub can pass it on to a low-speed device. Every packet opens with a header at the full-speed bit rate: a SYNC field followed by the PRE PID. Next comes an idle gap in the J state. The block then drops to the low-speed bit rate and sends the low-speed SYNC, the packet ID and the data bytes, and closes with an end-of-packet. The line outputs are NRZI-coded DP/DM levels with bit stuffing, plus an output enable.

All timing comes from a single full-speed bit strobe. The low-speed bit period is produced by counting that strobe. A command pulse carrying the packet ID starts a packet. The data bytes then arrive over a valid/take handshake, and the link ends the packet by raising a stop level. An idle watcher raises a suspend flag after the bus has been quiet for a set number of full-speed bit times.

Top module: `ls_pre_tx`

## Requirements
- R1: After `tx_go` is accepted in idle, the block emits one line symbol per `fs_bit_en` strobe. It first sends the SYNC byte 0x80 and then the PRE byte 0x3C, each LSB first. NRZI coding applies: a 0 bit toggles the line and a 1 bit holds it. The line starts from J. J is `line_dp`=1 and `line_dm`=0, and K is the reverse.
- R2: After the last PRE bit the line shows J for `GAP_BITS` (default 4) full-speed bit times. It is driven (`line_oe`=1) for the first `GAP_J_BITS` (default 1) of them and released (`line_oe`=0, lines still at J) for the rest.
- R3: The low-speed part follows the gap, starting from J. It sends SYNC 0x80, then the PID byte `{~tx_pid, tx_pid}`, then the data bytes, all LSB first and NRZI coded. Each bit is held for `RATIO` (default 8) full-speed strobes.
- R4: After `STUFF_RUN` (default 6) consecutive 1 bits, a 0 bit (a line transition) is inserted. This applies even when the run ends at a byte boundary or at the last data bit. The run count restarts at the first bit of the header and at the first bit of the low-speed SYNC.
- R5: The end-of-packet is two low-speed bit times of SE0 (both lines 0, driven) followed by one low-speed bit time of driven J. The block then releases the line and drops `busy`. `busy` is high from the accepting edge until that release.
- R6: `dat_take` pulses for exactly one cycle per consumed byte. It fires only in the low-speed phase, on the strobe that sends the last bit of the PID or of the previous data byte, and never during the header or the gap.
- R7: At each byte boundary after the PID, the packet ends if `link_stop` is high or `dat_valid` is low. In that case no byte is taken and the end-of-packet follows.
- R8: `tx_go` while `busy` is high is ignored and does not disturb the packet in flight.
- R9: `bus_suspended` rises once `SUSP_BITS` full-speed strobes have passed with the block idle and the line released. It is low while a packet is in progress.
- R10: During and right after reset, `line_oe`=0, the lines show J, `busy`=0, `ls_rate`=0 and `bus_suspended`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_bit_en | input | 1 | Full-speed bit strobe |
| tx_go | input | 1 | Start command, taken in idle |
| tx_pid | input | 4 | Low-speed packet ID for the command |
| dat_valid | input | 1 | Data byte on `dat_byte` is valid |
| dat_byte | input | 8 | Data byte |
| link_stop | input | 1 | Link has no more bytes; end the packet |
| dat_take | output | 1 | Byte consumed on this edge |
| line_dp | output | 1 | DP line level |
| line_dm | output | 1 | DM line level |
| line_oe | output | 1 | Line driven |
| busy | output | 1 | Packet in progress |
| ls_rate | output | 1 | Serializer runs at the low-speed rate |
| bus_suspended | output | 1 | Bus quiet for the suspend time |

## Verification
Two functions can fall on the same low-speed strobe: the stuff insertion and a byte-boundary decision, which is either a data take or the start of the end-of-packet. A data byte 0xFC ends in six 1 bits. Placing it before another byte, and again as the final byte, forces the stuffed transition onto the strobe where the take or the SE0 would otherwise occur. A packet whose PID byte ends in four 1 bits, followed by a byte that opens with two 1 bits, carries a run across the PID boundary. A scoreboard built from the requirements predicts every line symbol and the number of takes for each packet. A shifted or missing stuff bit, or an early take, therefore shows up as a symbol mismatch or a wrong take count.

// File: rtl/ls_pre_pkg.sv
package ls_pre_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HSYNC,
      ST_HPID,
      ST_GAP,
      ST_LSYNC,
      ST_LPID,
      ST_LDATA,
      ST_EOP_SE0,
      ST_EOP_J
   } seq_st_e;

   typedef enum logic [1:0] {
      SH_NONE,
      SH_BIT,
      SH_J,
      SH_SE0
   } shape_cmd_e;

   // SYNC pattern, LSB first: seven zeros then a one
   localparam logic [7:0] SYNC_BYTE = 8'h80;
   // preamble token with its check nibble
   localparam logic [7:0] PRE_BYTE  = 8'h3C;

   function automatic logic [7:0] pid_byte(input logic [3:0] p);
      return {~p, p};
   endfunction

endpackage

// File: rtl/ls_rate_div.sv
module ls_rate_div #(
   parameter int RATIO = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fs_stb,
   input  logic restart,
   output logic ls_stb
);

   if (RATIO < 1) begin : g_bad_ratio
      $error("ls_rate_div: RATIO must be at least 1");
   end

   if (RATIO == 1) begin : g_pass
      assign ls_stb = fs_stb & ~restart;
   end else begin : g_count
      localparam int CW = $clog2(RATIO);
      localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (restart) begin
            cnt_q <= '0;
         end else if (fs_stb) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end

      assign ls_stb = fs_stb && !restart && (cnt_q == LAST);
   end

endmodule

// File: rtl/ls_line_shaper.sv
module ls_line_shaper
   import ls_pre_pkg::*;
#(
   parameter int STUFF_RUN = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  shape_cmd_e cmd,
   input  logic       bit_in,
   input  logic       restart_run,
   output logic       lvl_o,
   output logic       se0_o,
   output logic       stuff_pend_o
);

   if (STUFF_RUN < 1) begin : g_bad_run
      $error("ls_line_shaper: STUFF_RUN must be at least 1");
   end

   localparam int RW = $clog2(STUFF_RUN + 1);
   localparam logic [RW-1:0] RUN_MAX = RW'(STUFF_RUN);

   logic [RW-1:0] ones_q;
   logic          lvl_q;
   logic          se0_q;

   assign stuff_pend_o = (ones_q == RUN_MAX);
   assign lvl_o        = lvl_q;
   assign se0_o        = se0_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
         lvl_q  <= 1'b1;
         se0_q  <= 1'b0;
      end else if (step) begin
         case (cmd)
            SH_BIT: begin
               se0_q <= 1'b0;
               if (stuff_pend_o && !restart_run) begin
                  lvl_q  <= ~lvl_q;
                  ones_q <= '0;
               end else if (!bit_in) begin
                  lvl_q  <= ~lvl_q;
                  ones_q <= '0;
               end else if (restart_run) begin
                  ones_q <= RW'(1);
               end else begin
                  ones_q <= ones_q + 1'b1;
               end
            end
            SH_J: begin
               lvl_q  <= 1'b1;
               se0_q  <= 1'b0;
               ones_q <= '0;
            end
            SH_SE0: begin
               se0_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   AST_STUFF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cmd == SH_BIT && stuff_pend_o && !restart_run) |=> (lvl_q != $past(lvl_q))); // R4

endmodule

// File: rtl/ls_idle_watch.sv
module ls_idle_watch #(
   parameter int SUSP_BITS = 36000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fs_stb,
   input  logic active,
   output logic suspended
);

   if (SUSP_BITS < 1) begin : g_bad_susp
      $error("ls_idle_watch: SUSP_BITS must be at least 1");
   end

   localparam int CW = $clog2(SUSP_BITS + 1);
   localparam logic [CW-1:0] LIM = CW'(SUSP_BITS);

   logic [CW-1:0] quiet_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_q <= '0;
      end else if (active) begin
         quiet_q <= '0;
      end else if (fs_stb && quiet_q != LIM) begin
         quiet_q <= quiet_q + 1'b1;
      end
   end

   assign suspended = (quiet_q == LIM);

   AST_SUSP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> !suspended); // R9

endmodule

// File: rtl/ls_pre_tx.sv
module ls_pre_tx
   import ls_pre_pkg::*;
#(
   parameter int RATIO      = 8,
   parameter int GAP_BITS   = 4,
   parameter int GAP_J_BITS = 1,
   parameter int STUFF_RUN  = 6,
   parameter int SUSP_BITS  = 36000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fs_bit_en,
   input  logic       tx_go,
   input  logic [3:0] tx_pid,
   input  logic       dat_valid,
   input  logic [7:0] dat_byte,
   input  logic       link_stop,
   output logic       dat_take,
   output logic       line_dp,
   output logic       line_dm,
   output logic       line_oe,
   output logic       busy,
   output logic       ls_rate,
   output logic       bus_suspended
);

   if (GAP_BITS < 4) begin : g_bad_gap
      $error("ls_pre_tx: GAP_BITS below four full-speed bit times");
   end
   if (GAP_J_BITS < 1 || GAP_J_BITS > GAP_BITS) begin : g_bad_gapj
      $error("ls_pre_tx: GAP_J_BITS must lie in 1..GAP_BITS");
   end

   localparam int GW = $clog2(GAP_BITS + 1);
   localparam logic [GW-1:0] GAP_END   = GW'(GAP_BITS);
   localparam logic [GW-1:0] GAP_DRIVE = GW'(GAP_J_BITS);

   seq_st_e       st_q, st_d;
   logic [7:0]    sh_q, sh_d;
   logic [2:0]    bcnt_q, bcnt_d;
   logic [3:0]    pid_q, pid_d;
   logic [GW-1:0] gcnt_q, gcnt_d;
   logic [1:0]    ecnt_q, ecnt_d;
   logic          oe_q, oe_d;
   logic          ls_q, ls_d;

   shape_cmd_e    sh_cmd;
   logic          sh_bit;
   logic          restart_run;
   logic          div_restart;
   logic          ls_stb;
   logic          tick;
   logic          stuff_pend;
   logic          lvl;
   logic          se0;
   logic          more;

   ls_rate_div #(.RATIO(RATIO)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .fs_stb  (fs_bit_en),
      .restart (div_restart),
      .ls_stb  (ls_stb)
   );

   ls_line_shaper #(.STUFF_RUN(STUFF_RUN)) u_shape (
      .clk          (clk),
      .rst_n        (rst_n),
      .step         (tick),
      .cmd          (sh_cmd),
      .bit_in       (sh_bit),
      .restart_run  (restart_run),
      .lvl_o        (lvl),
      .se0_o        (se0),
      .stuff_pend_o (stuff_pend)
   );

   ls_idle_watch #(.SUSP_BITS(SUSP_BITS)) u_idle (
      .clk       (clk),
      .rst_n     (rst_n),
      .fs_stb    (fs_bit_en),
      .active    (busy | oe_q),
      .suspended (bus_suspended)
   );

   assign tick = ls_q ? ls_stb : fs_bit_en;
   assign more = dat_valid && !link_stop;

   always_comb begin
      st_d        = st_q;
      sh_d        = sh_q;
      bcnt_d      = bcnt_q;
      pid_d       = pid_q;
      gcnt_d      = gcnt_q;
      ecnt_d      = ecnt_q;
      oe_d        = oe_q;
      ls_d        = ls_q;
      sh_cmd      = SH_NONE;
      sh_bit      = sh_q[0];
      restart_run = 1'b0;
      div_restart = 1'b0;
      dat_take    = 1'b0;

      case (st_q)
         ST_IDLE: begin
            if (tx_go) begin
               pid_d  = tx_pid;
               sh_d   = SYNC_BYTE;
               bcnt_d = '0;
               st_d   = ST_HSYNC;
            end
         end

         ST_HSYNC, ST_HPID, ST_LSYNC, ST_LPID, ST_LDATA: begin
            if (tick) begin
               sh_cmd      = SH_BIT;
               restart_run = (st_q == ST_HSYNC) && (bcnt_q == 3'd0);
               if (!stuff_pend || restart_run) begin
                  oe_d   = 1'b1;
                  sh_d   = {1'b0, sh_q[7:1]};
                  bcnt_d = bcnt_q + 3'd1;
                  if (bcnt_q == 3'd7) begin
                     case (st_q)
                        ST_HSYNC: begin
                           sh_d = PRE_BYTE;
                           st_d = ST_HPID;
                        end
                        ST_HPID: begin
                           gcnt_d = '0;
                           st_d   = ST_GAP;
                        end
                        ST_LSYNC: begin
                           sh_d = pid_byte(pid_q);
                           st_d = ST_LPID;
                        end
                        default: begin
                           if (more) begin
                              sh_d     = dat_byte;
                              dat_take = 1'b1;
                              st_d     = ST_LDATA;
                           end else begin
                              ecnt_d = '0;
                              st_d   = ST_EOP_SE0;
                           end
                        end
                     endcase
                  end
               end
            end
         end

         ST_GAP: begin
            if (tick) begin
               if (gcnt_q < GAP_END) begin
                  sh_cmd = SH_J;
                  oe_d   = (gcnt_q < GAP_DRIVE);
                  gcnt_d = gcnt_q + 1'b1;
               end else begin
                  sh_cmd      = SH_BIT;
                  sh_bit      = SYNC_BYTE[0];
                  restart_run = 1'b1;
                  div_restart = 1'b1;
                  oe_d        = 1'b1;
                  ls_d        = 1'b1;
                  sh_d        = {1'b0, SYNC_BYTE[7:1]};
                  bcnt_d      = 3'd1;
                  st_d        = ST_LSYNC;
               end
            end
         end

         ST_EOP_SE0: begin
            if (tick) begin
               if (stuff_pend) begin
                  sh_cmd = SH_BIT;
               end else begin
                  sh_cmd = SH_SE0;
                  ecnt_d = ecnt_q + 2'd1;
                  if (ecnt_q == 2'd1) begin
                     st_d = ST_EOP_J;
                  end
               end
            end
         end

         ST_EOP_J: begin
            if (tick) begin
               sh_cmd = SH_J;
               if (ecnt_q == 2'd2) begin
                  ecnt_d = 2'd3;
               end else begin
                  oe_d = 1'b0;
                  ls_d = 1'b0;
                  st_d = ST_IDLE;
               end
            end
         end

         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         sh_q   <= '0;
         bcnt_q <= '0;
         pid_q  <= '0;
         gcnt_q <= '0;
         ecnt_q <= '0;
         oe_q   <= 1'b0;
         ls_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         sh_q   <= sh_d;
         bcnt_q <= bcnt_d;
         pid_q  <= pid_d;
         gcnt_q <= gcnt_d;
         ecnt_q <= ecnt_d;
         oe_q   <= oe_d;
         ls_q   <= ls_d;
      end
   end

   assign busy    = (st_q != ST_IDLE);
   assign ls_rate = ls_q;
   assign line_oe = oe_q;
   assign line_dp = lvl & ~se0;
   assign line_dm = ~lvl & ~se0;

   AST_TAKE_LS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      dat_take |-> ls_q); // R6

   AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tx_go) |=> $stable(pid_q)); // R8

   AST_SE0_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_dp && !line_dm) |-> line_oe); // R5

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !line_oe); // R5

endmodule

// File: tb/ls_pre_tx_tb_top.sv
module ls_pre_tx_tb_top;

   localparam int RATIO = 8;
   localparam int GAP   = 4;
   localparam int GAPJ  = 1;
   localparam int RUN   = 6;
   localparam int SUSP  = 300;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       fs_bit_en;
   logic       tx_go;
   logic [3:0] tx_pid;
   logic       dat_valid;
   logic [7:0] dat_byte;
   logic       link_stop;
   logic       dat_take;
   logic       line_dp;
   logic       line_dm;
   logic       line_oe;
   logic       busy;
   logic       ls_rate;
   logic       bus_suspended;

   always #5 clk = ~clk;

   ls_pre_tx #(
      .RATIO(RATIO), .GAP_BITS(GAP), .GAP_J_BITS(GAPJ),
      .STUFF_RUN(RUN), .SUSP_BITS(SUSP)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .fs_bit_en(fs_bit_en), .tx_go(tx_go),
      .tx_pid(tx_pid), .dat_valid(dat_valid), .dat_byte(dat_byte),
      .link_stop(link_stop), .dat_take(dat_take), .line_dp(line_dp),
      .line_dm(line_dm), .line_oe(line_oe), .busy(busy),
      .ls_rate(ls_rate), .bus_suspended(bus_suspended)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [2:0] exp_q[$];
   int         pkt_err;
   logic [2:0] first_act, first_exp;

   logic [7:0] dat_mem[8];
   int         dat_n    = 0;
   int         dat_idx  = 0;
   bit         use_stop = 1'b1;
   bit         took     = 1'b0;
   int         take_cnt = 0;
   int         take_hs  = 0;

   logic m_lvl;
   int   m_ones;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---- scoreboard model: symbol = {oe, dp, dm}
   task automatic push_rep(input logic [2:0] s, input int rep);
      for (int i = 0; i < rep; i++) exp_q.push_back(s);
   endtask

   task automatic m_bit(input logic b, input int rep);
      if (!b) begin
         m_lvl  = ~m_lvl;
         m_ones = 0;
      end else begin
         m_ones++;
      end
      push_rep({1'b1, m_lvl, ~m_lvl}, rep);
      if (m_ones == RUN) begin
         m_lvl  = ~m_lvl;
         m_ones = 0;
         push_rep({1'b1, m_lvl, ~m_lvl}, rep);
      end
   endtask

   task automatic m_byte(input logic [7:0] v, input int rep);
      for (int i = 0; i < 8; i++) m_bit(v[i], rep);
   endtask

   // ---- monitor: pops one expected symbol per full-speed strobe
   initial begin
      logic [2:0] act, e;
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            e   = exp_q.pop_front();
            act = {line_oe, line_dp, line_dm};
            if (act !== e) begin
               if (pkt_err == 0) begin
                  first_act = act;
                  first_exp = e;
               end
               pkt_err++;
            end
         end
      end
   end

   // ---- byte source
   initial begin
      forever begin
         @(negedge clk);
         if (took) dat_idx++;
         dat_valid = (dat_idx < dat_n);
         dat_byte  = dat_mem[dat_idx & 7];
         link_stop = use_stop && (dat_idx >= dat_n);
         #1;
         took = dat_take;
         if (dat_take) begin
            take_cnt++;
            if (!ls_rate) take_hs++;
         end
      end
   end

   task automatic send_pkt(input logic [3:0] pid, input int n, input bit stop,
                           input bit poke, input string tag);
      @(negedge clk);
      pkt_err  = 0;
      take_cnt = 0;
      take_hs  = 0;
      dat_n    = n;
      dat_idx  = 0;
      use_stop = stop;
      exp_q.push_back(3'b010);
      m_lvl  = 1'b1;
      m_ones = 0;
      m_byte(8'h80, 1);
      m_byte(8'h3C, 1);
      for (int g = 0; g < GAP; g++) exp_q.push_back({(g < GAPJ), 1'b1, 1'b0});
      m_lvl  = 1'b1;
      m_ones = 0;
      m_byte(8'h80, RATIO);
      m_byte({~pid, pid}, RATIO);
      for (int k = 0; k < n; k++) m_byte(dat_mem[k], RATIO);
      push_rep(3'b100, 2 * RATIO);
      push_rep(3'b110, RATIO);
      exp_q.push_back(3'b010);
      tx_pid = pid;
      tx_go  = 1'b1;
      @(negedge clk);
      tx_go = 1'b0;
      check(busy == 1'b1, {tag, " R5 busy after start"}, busy, 1);
      repeat (3) @(negedge clk);
      check(bus_suspended == 1'b0, {tag, " R9 suspend low in packet"}, bus_suspended, 0);
      if (poke) begin
         repeat (60) @(negedge clk);
         tx_pid = ~pid;
         tx_go  = 1'b1;
         @(negedge clk);
         tx_go = 1'b0;
      end
      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
      check(pkt_err == 0, {tag, " R1 R2 R3 R4 R5 R8 line stream"}, first_act, first_exp);
      check(take_cnt == n, {tag, " R6 R7 bytes taken"}, take_cnt, n);
      check(take_hs == 0, {tag, " R6 take outside low-speed phase"}, take_hs, 0);
      check(busy == 1'b0 && line_oe == 1'b0, {tag, " R5 released after end"},
            {busy, line_oe}, 0);
   endtask

   // ---- watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n     = 1'b0;
      fs_bit_en = 1'b1;
      tx_go     = 1'b0;
      tx_pid    = 4'h0;
      for (int i = 0; i < 8; i++) dat_mem[i] = 8'h00;
      repeat (4) @(negedge clk);
      check(line_oe == 1'b0 && line_dp == 1'b1 && line_dm == 1'b0, "R10 line idle in reset",
            {line_oe, line_dp, line_dm}, 3'b010);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0, "R10 busy low", busy, 0);
      check(ls_rate == 1'b0, "R10 rate full-speed", ls_rate, 0);
      check(bus_suspended == 1'b0, "R10 suspend low", bus_suspended, 0);
      check(dat_take == 1'b0, "R10 no take", dat_take, 0);

      // R9: quiet-bus timer, 1 + 249 strobes so far vs 300
      repeat (249) @(negedge clk);
      check(bus_suspended == 1'b0, "R9 before suspend time", bus_suspended, 0);
      repeat (70) @(negedge clk);
      check(bus_suspended == 1'b1, "R9 after suspend time", bus_suspended, 1);

      // plain packet with two bytes
      dat_mem[0] = 8'h01;
      dat_mem[1] = 8'hA5;
      send_pkt(4'h9, 2, 1'b1, 1'b0, "pktA");

      // stuffing on a byte boundary and before the end; R8 start pulse mid-packet
      dat_mem[0] = 8'hFC;
      dat_mem[1] = 8'h12;
      dat_mem[2] = 8'hFC;
      send_pkt(4'h3, 3, 1'b1, 1'b1, "pktB");

      // R7 stop right after the PID, no data
      send_pkt(4'hA, 0, 1'b1, 1'b0, "pktC");

      // R7 end on missing valid with stop low; long ones run R4
      dat_mem[0] = 8'hFF;
      dat_mem[1] = 8'h7E;
      send_pkt(4'h1, 2, 1'b0, 1'b0, "pktD");

      // R4 run across the PID to data boundary
      dat_mem[0] = 8'h03;
      send_pkt(4'h0, 1, 1'b1, 1'b0, "pktE");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule